// File: doc/BRIEF.md
# SONET Frame Detector and Byte Aligner

The block sits behind a serial receiver and sees one line bit on every high-speed clock. It gathers the bits into bytes and watches every bit position for the SONET/SDH framing header: three A1 bytes (`8'hF6`) directly followed by three A2 bytes (`8'h28`). When the header is seen while the out-of-frame level input is high, the byte boundary snaps to the header. The byte on the output is then the third A2, and a frame pulse marks that same byte.

Bytes leave the block on a parallel bus that is qualified by a one-cycle byte strobe. The strobe fires once every eight bit clocks. The out-of-frame input is a level. While it is high, the block keeps hunting and realigns on every header it finds. While it is low, the last boundary is held, the strobe spacing does not change and no frame pulse is produced. A synchronous active-low reset clears the bit window, the byte phase counter and the outputs.

Top module: `sonet_frame_aligner`

## Requirements
- R1: Each byte on `byte_o` holds eight consecutive received bits with the earliest in bit 7. It is the eight bits whose last bit entered at the rising edge before the one at which `byte_vld_o` is raised.
- R2: A frame is recognised only on the 48-bit run F6 F6 F6 28 28 28. A run with only two A1 bytes or only two A2 bytes gives no frame pulse.
- R3: A header that arrives while `oof_i` is low neither moves the byte boundary nor raises `frame_pulse_o`.
- R4: While `oof_i` stays high, a later header at a different bit offset realigns the boundary again and raises a new frame pulse.
- R5: On detection the first aligned byte is the third A2 (28). The bytes after it are the bits that follow the header, in whole-byte steps.
- R6: `frame_pulse_o` rises together with the `byte_vld_o` of the third A2 byte. It stays high for exactly one byte period of eight clocks, unless `oof_i` falls first.
- R7: `frame_pulse_o` is never high while `oof_i` is low.
- R8: During reset `byte_o`, `byte_vld_o` and `frame_pulse_o` are 0. The first strobe after reset release comes eight clocks after the first active edge.
- R9: Outside a realignment, `byte_vld_o` is a one-cycle strobe exactly every eight clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| oof_i | input | 1 | Out-of-frame level; high enables hunting and realignment |
| ser_bit_i | input | 1 | Serial line bit |
| byte_o | output | 8 | Aligned parallel byte, earliest bit in bit 7 |
| byte_vld_o | output | 1 | One-cycle strobe marking a new byte on `byte_o` |
| frame_pulse_o | output | 1 | High for the byte period of the aligned third A2 |

## Verification
The bound checker watches the frame pulse on every cycle. The pulse must sit on an A2 byte, must only rise with a strobe, and must vanish whenever the out-of-frame input is low. The checker also watches the strobe spacing: it must be exactly eight clocks whenever no realignment was allowed, and it must never grow longer than eight. Only the directed scenarios can show the rest. That covers whether a header at an arbitrary bit offset is found, whether near-miss headers are rejected, and whether the bytes after the header come out in the new alignment. The bench checks every strobed byte against its own record of the sent bits.

// File: rtl/sfd_pkg.sv
// Package: shared constants and helpers for the frame aligner.
// Assumes byte-oriented framing with equal counts of A1 and A2 bytes.
package sfd_pkg;
    localparam int unsigned BYTE_W_DEF = 8;
    localparam int unsigned HDR_N_DEF  = 3;
    localparam logic [7:0]  A1_DEF     = 8'hF6;
    localparam logic [7:0]  A2_DEF     = 8'h28;
endpackage

// File: rtl/sfd_bit_window.sv
// Sliding window of the most recent WIN_W line bits.
// Newest bit enters at bit 0, so the oldest bit sits at the MSB.
module sfd_bit_window #(
    parameter int unsigned WIN_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_i,
    output logic [WIN_W-1:0] win_o
);
    // Shift one bit per clock; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) win_o <= '0;
        else        win_o <= {win_o[WIN_W-2:0], bit_i};
    end
endmodule

// File: rtl/sfd_hdr_match.sv
// Compares the bit window against HDR_N A1 bytes followed by HDR_N A2 bytes.
// Assumes the window width equals 2*HDR_N*BYTE_W.
module sfd_hdr_match #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned HDR_N  = 3,
    parameter logic [BYTE_W-1:0] A1_VAL = 8'hF6,
    parameter logic [BYTE_W-1:0] A2_VAL = 8'h28,
    localparam int unsigned PAT_W = 2*HDR_N*BYTE_W
) (
    input  logic [PAT_W-1:0] win_i,
    output logic             hit_o
);
    logic [PAT_W-1:0] pattern;

    // Build the header pattern, oldest byte in the top slice.
    for (genvar g = 0; g < 2*HDR_N; g++) begin : g_pat
        if (g < HDR_N) begin : g_a1
            assign pattern[PAT_W-1-g*BYTE_W -: BYTE_W] = A1_VAL;
        end else begin : g_a2
            assign pattern[PAT_W-1-g*BYTE_W -: BYTE_W] = A2_VAL;
        end
    end

    // Full-width compare at the current bit offset.
    assign hit_o = (win_i == pattern);
endmodule

// File: rtl/sfd_byte_phase.sv
// Byte phase counter: ticks every BYTE_W clocks, restarts on realign.
// Assumes realign_i is already qualified by the out-of-frame level.
module sfd_byte_phase #(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic realign_i,
    output logic tick_o
);
    logic [CNT_W-1:0] cnt;

    assign tick_o = realign_i || (cnt == CNT_W'(BYTE_W-1));

    // Count bits since the last byte capture.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (tick_o) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sfd_out_stage.sv
// Output registers: captures the aligned byte, its strobe and the frame flag.
// Assumes byte_i is the newest BYTE_W bits of the window.
module sfd_out_stage #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              realign_i,
    input  logic              oof_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              vld_o,
    output logic              frame_o
);
    logic fp_q;

    // Capture the byte and raise the strobe on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_o <= '0;
            vld_o  <= 1'b0;
        end else begin
            vld_o <= tick_i;
            if (tick_i) byte_o <= byte_i;
        end
    end

    // Frame flag lives for one byte period; dropped when out-of-frame is low.
    always_ff @(posedge clk) begin
        if (!rst_n)      fp_q <= 1'b0;
        else if (!oof_i) fp_q <= 1'b0;
        else if (tick_i) fp_q <= realign_i;
    end

    assign frame_o = fp_q && oof_i;
endmodule

// File: rtl/sonet_frame_aligner.sv
// Top: serial-to-byte converter with header hunt and boundary realignment.
// Assumes one line bit per clk; oof_i is a synchronous level.
module sonet_frame_aligner #(
    parameter int unsigned BYTE_W = sfd_pkg::BYTE_W_DEF,
    parameter int unsigned HDR_N  = sfd_pkg::HDR_N_DEF,
    parameter logic [BYTE_W-1:0] A1_VAL = sfd_pkg::A1_DEF,
    parameter logic [BYTE_W-1:0] A2_VAL = sfd_pkg::A2_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oof_i,
    input  logic              ser_bit_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_vld_o,
    output logic              frame_pulse_o
);
    localparam int unsigned WIN_W = 2*HDR_N*BYTE_W;

    logic [WIN_W-1:0] win;
    logic             hit;
    logic             realign;
    logic             tick;

    sfd_bit_window #(.WIN_W(WIN_W)) u_win (
        .clk(clk), .rst_n(rst_n), .bit_i(ser_bit_i), .win_o(win)
    );

    sfd_hdr_match #(
        .BYTE_W(BYTE_W), .HDR_N(HDR_N), .A1_VAL(A1_VAL), .A2_VAL(A2_VAL)
    ) u_match (
        .win_i(win), .hit_o(hit)
    );

    // Realignment is allowed only while out-of-frame is high.
    assign realign = hit && oof_i;

    sfd_byte_phase #(.BYTE_W(BYTE_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .realign_i(realign), .tick_o(tick)
    );

    sfd_out_stage #(.BYTE_W(BYTE_W)) u_out (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .realign_i(realign),
        .oof_i(oof_i), .byte_i(win[BYTE_W-1:0]),
        .byte_o(byte_o), .vld_o(byte_vld_o), .frame_o(frame_pulse_o)
    );
endmodule

// File: rtl/sfd_checker.sv
// Checker: port-level timing rules of the frame aligner.
// Assumes it is bound to sonet_frame_aligner.
module sfd_checker #(
    parameter int unsigned BYTE_W = 8,
    parameter logic [BYTE_W-1:0] A2_VAL = 8'h28,
    localparam int unsigned GAP_W = ((BYTE_W > 1) ? $clog2(BYTE_W) : 1) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              oof_i,
    input logic [BYTE_W-1:0] byte_o,
    input logic              byte_vld_o,
    input logic              frame_pulse_o
);
    logic [GAP_W-1:0] gap;
    logic             seen;

    // Clocks since the last strobe, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (byte_vld_o) begin
            gap  <= '0;
            seen <= 1'b1;
        end else if (gap != {GAP_W{1'b1}}) begin
            gap <= gap + 1'b1;
        end
    end

    AST_FP_NEEDS_OOF: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse_o |-> oof_i); // R7
    AST_FP_ON_A2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse_o |-> (byte_o == A2_VAL)); // R6
    AST_FP_RISES_WITH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_pulse_o) |-> byte_vld_o); // R6
    AST_HELD_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && byte_vld_o && !$past(oof_i)) |-> (gap == GAP_W'(BYTE_W-1))); // R3
    AST_NO_LONG_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && gap == GAP_W'(BYTE_W-1)) |-> byte_vld_o); // R9
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!byte_vld_o && !frame_pulse_o)); // R8
endmodule

bind sonet_frame_aligner sfd_checker #(.BYTE_W(BYTE_W), .A2_VAL(A2_VAL)) u_sfd_chk (
    .clk(clk), .rst_n(rst_n), .oof_i(oof_i), .byte_o(byte_o),
    .byte_vld_o(byte_vld_o), .frame_pulse_o(frame_pulse_o)
);

// File: tb/sonet_frame_aligner_tb_top.sv
`timescale 1ns/1ps
module sonet_frame_aligner_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       oof_i = 1'b0;
    logic       ser_bit_i = 1'b0;
    logic [7:0] byte_o;
    logic       byte_vld_o;
    logic       frame_pulse_o;

    sonet_frame_aligner dut_i (
        .clk(clk), .rst_n(rst_n), .oof_i(oof_i), .ser_bit_i(ser_bit_i),
        .byte_o(byte_o), .byte_vld_o(byte_vld_o), .frame_pulse_o(frame_pulse_o)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic hist [0:2047];
    int nsent, cyc, rel_cyc, fp_cycles, fp_bad;
    bit rel_pending;
    logic [7:0] lb [0:511];
    logic       lf [0:511];
    int         lc [0:511];
    int nl;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected byte from the sent-bit record (R1 timing).
    function automatic logic [7:0] exp_byte();
        logic [7:0] e;
        for (int k = 0; k < 8; k++) begin
            int idx = nsent - 9 + k;
            e[7-k] = (idx >= 0) ? hist[idx] : 1'b0;
        end
        return e;
    endfunction

    task automatic sample();
        cyc++;
        if (frame_pulse_o && !oof_i) fp_bad++;
        if (frame_pulse_o) fp_cycles++;
        if (byte_vld_o) begin
            chk(byte_o == exp_byte(), "R1 byte content", byte_o, exp_byte());
            lb[nl] = byte_o; lf[nl] = frame_pulse_o; lc[nl] = cyc; nl++;
        end
    endtask

    task automatic step(input logic b);
        @(negedge clk);
        sample();
        if (rel_pending) begin
            rst_n = 1'b1; rel_pending = 0; rel_cyc = cyc;
        end
        ser_bit_i = b; hist[nsent] = b; nsent++;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) step(b[i]);
    endtask

    task automatic zeros(input int n);
        for (int i = 0; i < n; i++) step(1'b0);
    endtask

    task automatic send_hdr();
        for (int i = 0; i < 3; i++) send_byte(8'hF6);
        for (int i = 0; i < 3; i++) send_byte(8'h28);
    endtask

    task automatic do_reset(input logic oof);
        rst_n = 1'b0; oof_i = oof; ser_bit_i = 1'b0;
        repeat (3) @(negedge clk);
        nsent = 0; nl = 0; fp_cycles = 0; fp_bad = 0; rel_pending = 1;
    endtask

    function automatic int count_fp(input int from);
        int c = 0;
        for (int i = from; i < nl; i++) if (lf[i]) c++;
        return c;
    endfunction

    function automatic int find_fp(input int from);
        for (int i = from; i < nl; i++) if (lf[i]) return i;
        return -1;
    endfunction

    task automatic chk_gaps(input int from, input string tag);
        bit ok = 1; int bad = 8;
        for (int i = from + 1; i < nl; i++)
            if (lc[i] - lc[i-1] != 8) begin ok = 0; bad = lc[i] - lc[i-1]; end
        chk(ok, tag, bad, 8);
    endtask

    // R8: reset state and first strobe timing.
    task automatic t_reset();
        do_reset(1'b0);
        @(negedge clk);
        chk(byte_o == 8'h00, "R8 byte in reset", byte_o, 0);
        chk(!byte_vld_o, "R8 strobe in reset", byte_vld_o, 0);
        chk(!frame_pulse_o, "R8 pulse in reset", frame_pulse_o, 0);
        zeros(20);
        chk(nl > 0 && lc[0] - rel_cyc == 8, "R8 first strobe delay", lc[0] - rel_cyc, 8);
    endtask

    // R1/R9: MSB-first bytes with free-running alignment.
    task automatic t_msb_first();
        do_reset(1'b0);
        zeros(7); send_byte(8'hA5); send_byte(8'h3C); zeros(16);
        chk(lb[1] == 8'hA5, "R1 first byte", lb[1], 8'hA5);
        chk(lb[2] == 8'h3C, "R1 second byte", lb[2], 8'h3C);
        chk_gaps(0, "R9 strobe spacing");
    endtask

    // R2/R5/R6: header at bit offset 3.
    task automatic t_detect();
        int f;
        do_reset(1'b1);
        zeros(3); send_hdr(); send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); zeros(16);
        f = find_fp(0);
        chk(count_fp(0) == 1, "R2 one frame found", count_fp(0), 1);
        chk(f >= 0 && lb[f] == 8'h28, "R5 first aligned byte", (f >= 0) ? lb[f] : 0, 8'h28);
        chk(f >= 0 && lb[f+1] == 8'h11 && lb[f+2] == 8'h22 && lb[f+3] == 8'h33,
            "R5 following bytes", (f >= 0) ? lb[f+1] : 0, 8'h11);
        chk(fp_cycles == 8, "R6 pulse width", fp_cycles, 8);
        chk(f >= 0 && lc[f+1] - lc[f] == 8, "R9 spacing after realign", (f >= 0) ? lc[f+1] - lc[f] : 0, 8);
    endtask

    // R2: near-miss headers.
    task automatic t_near_miss();
        do_reset(1'b1);
        zeros(5);
        send_byte(8'hF6); send_byte(8'hF6);
        for (int i = 0; i < 3; i++) send_byte(8'h28);
        send_byte(8'h11); zeros(2);
        for (int i = 0; i < 3; i++) send_byte(8'hF6);
        send_byte(8'h28); send_byte(8'h28); send_byte(8'h11); zeros(16);
        chk(count_fp(0) == 0, "R2 near miss ignored", count_fp(0), 0);
        chk(fp_cycles == 0, "R2 no pulse", fp_cycles, 0);
    endtask

    // R3/R7: header while out-of-frame is low.
    task automatic t_oof_low();
        int mark;
        do_reset(1'b1);
        zeros(3); send_hdr(); send_byte(8'h11); send_byte(8'h22);
        oof_i = 1'b0;
        mark = nl;
        zeros(5); send_hdr(); send_byte(8'h11); send_byte(8'h22); zeros(16);
        chk(count_fp(mark) == 0, "R3 no pulse with oof low", count_fp(mark), 0);
        chk_gaps(mark > 0 ? mark - 1 : 0, "R3 boundary held");
        chk(fp_bad == 0, "R7 pulse while oof low", fp_bad, 0);
    endtask

    // R4: second header at a new offset re-aligns.
    task automatic t_rehunt();
        int f2;
        do_reset(1'b1);
        zeros(3); send_hdr(); send_byte(8'h11); send_byte(8'h22);
        zeros(6); send_hdr(); send_byte(8'h33); send_byte(8'h44); zeros(16);
        chk(count_fp(0) == 2, "R4 two frames", count_fp(0), 2);
        f2 = find_fp(find_fp(0) + 1);
        chk(f2 > 0 && lb[f2] == 8'h28 && lb[f2+1] == 8'h33 && lb[f2+2] == 8'h44,
            "R4 new alignment", (f2 > 0) ? lb[f2+1] : 0, 8'h33);
        chk(fp_cycles == 16, "R6 two pulse widths", fp_cycles, 16);
    endtask

    // R7: out-of-frame drops during a pulse.
    task automatic t_oof_drop();
        do_reset(1'b1);
        zeros(1); send_hdr(); zeros(2);
        oof_i = 1'b0;
        zeros(16);
        chk(count_fp(0) == 1, "R5 frame before drop", count_fp(0), 1);
        chk(fp_cycles == 1, "R7 pulse cut by oof", fp_cycles, 1);
        chk(fp_bad == 0, "R7 never with oof low", fp_bad, 0);
    endtask

    initial begin
        t_reset();
        t_msb_first();
        t_detect();
        t_near_miss();
        t_oof_low();
        t_rehunt();
        t_oof_drop();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule